// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block sequences a 32-bit load/store processor whose instructions take several clock cycles each. It does not drive the datapath itself. It holds a ten-state register, picks the next state from the current state and the 6-bit opcode that sits in the instruction register, and decodes each state into the enables and multiplexer selects the datapath needs for that step. The supported instruction classes are register-to-register ALU operations, load word, store word, branch-if-equal and jump. All of them share one instruction-fetch step and one decode step. The decode step also uses the otherwise idle ALU to form the branch target ahead of time.

Most outputs depend only on the state (Moore style). One output, the PC load enable, also depends on the ALU zero flag, and only in the branch step. The sequence lengths are: ALU operation 4 cycles, load 5, store 4, branch 3, jump 3. An opcode that is not recognised costs 2 cycles, fetch and decode, and writes nothing.

Top module: `mcyc_control`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch step (state code 0) at the next rising edge, from any state. Fetch is recognised at the ports by `irWrite`=1.
- R2: The fetch step drives `memRead`=1, `irWrite`=1, `pcWrite`=1, `aluSrcA`=0, `aluSrcB`=01 (constant 4), `aluOp`=00 (add) and `pcSrc`=00 (ALU result). It is always followed by the decode step.
- R3: After decode, the next step is chosen by opcode: 000000 (ALU operation) goes to execute, 100011 (load) and 101011 (store) go to address compute, 000100 (branch-if-equal) goes to branch, and 000010 (jump) goes to jump.
- R4: Any other opcode returns from decode straight to fetch, with no register, memory or PC write during that instruction.
- R5: Address compute drives `aluSrcA`=1, `aluSrcB`=10 (sign-extended immediate) and `aluOp`=00. It goes to the memory-read step for a load and to the memory-write step for a store. The memory-read step drives `memRead`=1 and `addrSel`=1 (address from ALUout), and it is followed by load write-back.
- R6: Execute drives `aluSrcA`=1, `aluSrcB`=00 and `aluOp`=10 (function field), and it is followed by register write-back. Register write-back drives `regWrite`=1 and `regDstSel`=1 (rd). Load write-back drives `regWrite`=1 and `wbDataSel`=1 (memory data). Both write-back steps, the store step, the branch step and the jump step return to fetch.
- R7: `pcWrite` is 1 only in fetch and jump. Jump drives `pcSrc`=10 (jump target).
- R8: `aluSrcA` is 0 (PC) in fetch and decode, and 1 (register A) in address compute, execute and branch.
- R9: The branch step drives `pcWriteCond`=1, `pcSrc`=01 (ALUout), `aluSrcA`=1, `aluSrcB`=00 and `aluOp`=01 (subtract). `pcLoadEn` equals `pcWrite` OR (`pcWriteCond` AND `aluZero`), so in the branch step it follows `aluZero` in the same cycle.
- R10: Decode drives `aluSrcA`=0, `aluSrcB`=11 (immediate shifted left by two) and `aluOp`=00, so that the branch target is formed into ALUout. Decode writes nothing.
- R11: `memWrite` is 1 only in the store step, where `addrSel`=1. `memRead` and `memWrite` are never both 1. Every strobe not named for a step is 0 in that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| aluZero | input | 1 | ALU result-is-zero flag |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write qualified by aluZero |
| pcLoadEn | output | 1 | Combined PC load enable |
| irWrite | output | 1 | Instruction register load |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| addrSel | output | 1 | Memory address: 0 PC, 1 ALUout |
| regWrite | output | 1 | Register file write |
| regDstSel | output | 1 | Destination: 0 rt, 1 rd |
| wbDataSel | output | 1 | Write data: 0 ALUout, 1 memory data |
| aluSrcA | output | 1 | ALU A: 0 PC, 1 register A |
| aluSrcB | output | 2 | ALU B: 00 B, 01 four, 10 imm, 11 imm<<2 |
| aluOp | output | 2 | 00 add, 01 subtract, 10 function field |
| pcSrc | output | 2 | PC source: 00 ALU, 01 ALUout, 10 jump target |

## Verification
All 64 opcodes are run through a whole instruction, starting from fetch. This separates the five recognised encodings from the 59 that must fall back after decode and write nothing, and each case is checked by its cycle count and by its full strobe vector. Branch-if-equal is run with the zero flag held low and held high, which shows that only the branch step passes the flag through to the PC load enable. The zero flag is also toggled every cycle during the other instructions, so that any leak of the flag into another step shows up. A reset asserted in the middle of a load shows that reset overrides the sequence.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MEMRD   = 4'd3,
    ST_LOADWB  = 4'd4,
    ST_MEMWR   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_REGWB   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } ctrlState_e;

  typedef enum logic [1:0] {SRCB_REG = 2'b00, SRCB_FOUR = 2'b01,
                            SRCB_IMM = 2'b10, SRCB_IMMSH = 2'b11} srcB_e;
  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01,
                            OP_FUNCT = 2'b10, OP_RSVD = 2'b11} aluOp_e;
  typedef enum logic [1:0] {PCS_ALU = 2'b00, PCS_ALUOUT = 2'b01,
                            PCS_JUMP = 2'b10, PCS_RSVD = 2'b11} pcSrc_e;

  typedef struct packed {
    logic   pcWrite;
    logic   pcWriteCond;
    logic   irWrite;
    logic   memRead;
    logic   memWrite;
    logic   addrSel;
    logic   regWrite;
    logic   regDstSel;
    logic   wbDataSel;
    logic   aluSrcA;
    srcB_e  aluSrcB;
    aluOp_e aluOp;
    pcSrc_e pcSrc;
  } ctrlStrobes_t;

endpackage

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrlState_e       curState
);

  ctrlState_e nextState;
  ctrlState_e dispatchState;

  // Dispatch out of decode, keyed on the opcode
  always_comb begin
    unique case (opcode)
      OPC_RTYPE:           dispatchState = ST_EXEC;
      OPC_LOAD, OPC_STORE: dispatchState = ST_ADDR;
      OPC_BEQ:             dispatchState = ST_BRANCH;
      OPC_JUMP:            dispatchState = ST_JUMP;
      default:             dispatchState = ST_FETCH;
    endcase
  end

  always_comb begin
    nextState = ST_FETCH;
    unique case (curState)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: nextState = dispatchState;
      ST_ADDR:   nextState = (opcode == OPC_STORE) ? ST_MEMWR : ST_MEMRD;
      ST_MEMRD:  nextState = ST_LOADWB;
      ST_EXEC:   nextState = ST_REGWB;
      ST_LOADWB, ST_REGWB, ST_MEMWR, ST_BRANCH, ST_JUMP:
                 nextState = ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nextState;
  end

endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
  import mcyc_pkg::*;
(
  input  ctrlState_e   curState,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.pcWrite = 1'b1;
        strobes.aluSrcB = SRCB_FOUR;
      end
      ST_DECODE: begin
        // branch target formed early while the ALU is free
        strobes.aluSrcB = SRCB_IMMSH;
      end
      ST_ADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_IMM;
      end
      ST_MEMRD: begin
        strobes.memRead = 1'b1;
        strobes.addrSel = 1'b1;
      end
      ST_LOADWB: begin
        strobes.regWrite  = 1'b1;
        strobes.wbDataSel = 1'b1;
      end
      ST_MEMWR: begin
        strobes.memWrite = 1'b1;
        strobes.addrSel  = 1'b1;
      end
      ST_EXEC: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluOp   = OP_FUNCT;
      end
      ST_REGWB: begin
        strobes.regWrite  = 1'b1;
        strobes.regDstSel = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = OP_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSrc       = PCS_ALUOUT;
      end
      ST_JUMP: begin
        strobes.pcWrite = 1'b1;
        strobes.pcSrc   = PCS_JUMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_control.sv
module mcyc_control
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       aluZero,
  output logic       pcWrite,
  output logic       pcWriteCond,
  output logic       pcLoadEn,
  output logic       irWrite,
  output logic       memRead,
  output logic       memWrite,
  output logic       addrSel,
  output logic       regWrite,
  output logic       regDstSel,
  output logic       wbDataSel,
  output logic       aluSrcA,
  output logic [1:0] aluSrcB,
  output logic [1:0] aluOp,
  output logic [1:0] pcSrc
);

  ctrlState_e   stateQ;
  logic [STATE_W-1:0] curState;
  ctrlStrobes_t strobes;

  mcyc_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .curState (stateQ)
  );

  mcyc_decode u_decode (
    .curState (stateQ),
    .strobes  (strobes)
  );

  assign curState    = stateQ;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign irWrite     = strobes.irWrite;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign addrSel     = strobes.addrSel;
  assign regWrite    = strobes.regWrite;
  assign regDstSel   = strobes.regDstSel;
  assign wbDataSel   = strobes.wbDataSel;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOp       = strobes.aluOp;
  assign pcSrc       = strobes.pcSrc;

  // the single Mealy term: branch taken only on a zero compare
  assign pcLoadEn = strobes.pcWrite | (strobes.pcWriteCond & aluZero);

endmodule

// File: rtl/mcyc_control_checker.sv
module mcyc_control_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       aluZero,
  input logic [3:0] curState,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       pcLoadEn,
  input logic       memRead,
  input logic       memWrite,
  input logic       aluSrcA,
  input logic [1:0] aluSrcB
);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> curState == 4'd0);

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    curState == 4'd0 |=> curState == 4'd1);

  assert_beq_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
    (curState == 4'd1 && opcode == 6'b000100) |=> curState == 4'd8);

  assert_pc_write_states_R7: assert property (@(posedge clk) disable iff (rst)
    pcWrite |-> (curState == 4'd0 || curState == 4'd9));

  assert_srca_register_R8: assert property (@(posedge clk) disable iff (rst)
    (curState == 4'd2 || curState == 4'd6 || curState == 4'd8) |-> aluSrcA);

  assert_branch_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (pcLoadEn && !pcWrite) |-> (pcWriteCond && aluZero));

  assert_decode_target_R10: assert property (@(posedge clk) disable iff (rst)
    curState == 4'd1 |-> (!aluSrcA && aluSrcB == 2'b11));

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

bind mcyc_control mcyc_control_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .opcode      (opcode),
  .aluZero     (aluZero),
  .curState    (curState),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond),
  .pcLoadEn    (pcLoadEn),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .aluSrcA     (aluSrcA),
  .aluSrcB     (aluSrcB)
);

// File: tb/mcyc_control_bench.sv
module mcyc_control_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic aluZero = 1'b0;
  logic pcWrite, pcWriteCond, pcLoadEn, irWrite, memRead, memWrite;
  logic addrSel, regWrite, regDstSel, wbDataSel, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSrc;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_control u_mcyc_control (
    .clk(clk), .rst(rst), .opcode(opcode), .aluZero(aluZero),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .pcLoadEn(pcLoadEn),
    .irWrite(irWrite), .memRead(memRead), .memWrite(memWrite),
    .addrSel(addrSel), .regWrite(regWrite), .regDstSel(regDstSel),
    .wbDataSel(wbDataSel), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
    .aluOp(aluOp), .pcSrc(pcSrc)
  );

  // bench-side step numbering, taken from the requirements
  localparam int F = 0, D = 1, AC = 2, MR = 3, LWB = 4, MW = 5, EX = 6, RWB = 7, BR = 8, JP = 9;

  function automatic int nextOf(int s, logic [5:0] op);
    case (s)
      F:  return D;
      D:  begin
            if (op == 6'b000000) return EX;
            if (op == 6'b100011 || op == 6'b101011) return AC;
            if (op == 6'b000100) return BR;
            if (op == 6'b000010) return JP;
            return F;
          end
      AC: return (op == 6'b101011) ? MW : MR;
      MR: return LWB;
      EX: return RWB;
      default: return F;
    endcase
  endfunction

  // {pcWrite,pcWriteCond,pcLoadEn,irWrite,memRead,memWrite,addrSel,regWrite,
  //  regDstSel,wbDataSel,aluSrcA,aluSrcB[1:0],aluOp[1:0],pcSrc[1:0]}
  function automatic logic [16:0] expVec(int s, logic z);
    logic [16:0] v;
    v = '0;
    case (s)
      F:   begin v[16] = 1; v[14] = 1; v[13] = 1; v[12] = 1; v[5:4] = 2'b01; end
      D:   v[5:4] = 2'b11;
      AC:  begin v[6] = 1; v[5:4] = 2'b10; end
      MR:  begin v[12] = 1; v[10] = 1; end
      LWB: begin v[9] = 1; v[7] = 1; end
      MW:  begin v[11] = 1; v[10] = 1; end
      EX:  begin v[6] = 1; v[3:2] = 2'b10; end
      RWB: begin v[9] = 1; v[8] = 1; end
      BR:  begin v[15] = 1; v[14] = z; v[6] = 1; v[3:2] = 2'b01; v[1:0] = 2'b01; end
      JP:  begin v[16] = 1; v[14] = 1; v[1:0] = 2'b10; end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string reqOf(int s);
    case (s)
      F: return "R2";  D: return "R10"; AC: return "R5"; MR: return "R5";
      LWB: return "R6"; MW: return "R11"; EX: return "R6"; RWB: return "R6";
      BR: return "R9"; default: return "R7";
    endcase
  endfunction

  function automatic int lengthOf(logic [5:0] op);
    if (op == 6'b100011) return 5;
    if (op == 6'b000000 || op == 6'b101011) return 4;
    if (op == 6'b000100 || op == 6'b000010) return 3;
    return 2;
  endfunction

  function automatic logic [16:0] actVec();
    return {pcWrite, pcWriteCond, pcLoadEn, irWrite, memRead, memWrite, addrSel,
            regWrite, regDstSel, wbDataSel, aluSrcA, aluSrcB, aluOp, pcSrc};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one whole instruction from fetch; zero mode 0 low, 1 high, 2 toggling
  task automatic runInstr(logic [5:0] op, int zeroMode);
    int s = F;
    int n = 0;
    bit wrote = 0;
    do begin
      opcode  = op;
      aluZero = (zeroMode == 2) ? logic'(n[0]) : logic'(zeroMode == 1);
      #1;
      check(reqOf(s), 32'(actVec()), 32'(expVec(s, aluZero)), "strobe vector");
      check("R7", 32'(pcWrite), 32'(s == F || s == JP), "pcWrite");
      if (s == F || s == D) check("R8", 32'(aluSrcA), 0, "aluSrcA");
      if (s == AC || s == EX || s == BR) check("R8", 32'(aluSrcA), 1, "aluSrcA");
      if (s != F && (regWrite || memWrite || pcLoadEn)) wrote = 1;
      @(posedge clk); #2;
      s = nextOf(s, op);
      n++;
    end while (s != F && n < 8);
    check("R3", 32'(n), 32'(lengthOf(op)), "instruction length");
    if (lengthOf(op) == 2) check("R4", 32'(wrote), 0, "write during unknown opcode");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'(actVec()), 32'(expVec(F, 1'b0)), "reset state");
    rst = 1'b0;
    for (int op = 0; op < 64; op++) runInstr(6'(op), 2);
    runInstr(6'b000100, 0);
    runInstr(6'b000100, 1);
    // reset in the middle of a load, at the memory-read step
    opcode = 6'b100011; aluZero = 1'b0;
    repeat (3) @(posedge clk);
    #2; #1;
    check("R5", 32'(actVec()), 32'(expVec(MR, 1'b0)), "memory-read step before reset");
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0; #1;
    check("R1", 32'(actVec()), 32'(expVec(F, 1'b0)), "reset mid-instruction");
    @(posedge clk); #3;
    check("R2", 32'(actVec()), 32'(expVec(D, 1'b0)), "decode after reset");
    done = 1;
  end

  initial begin
    while (!done && cycleCount < WATCHDOG) begin
      @(posedge clk);
      cycleCount++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycleCount);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule